// File: doc/BRIEF.md
# Sequencer Command and Control Register

This block holds the 16-bit global control word of a sampling converter and runs the small command engine behind it. Software writes the word to start or halt an instruction sequencer, to reset the converter, to request a short or a full offset calibration, and to enter or leave a low-power standby. It also writes three configuration bits: an auto-zero before every conversion, a channel-tag mask for result words, and the direction of a sync pin. Reading the word returns the live status: running, reset in progress, calibration pending or busy, and standby.

The block tracks a 3-bit instruction pointer that advances each time the sequencer reports a finished instruction. A stop or a calibration request that arrives while an instruction is in flight waits for that report. Calibrations are modelled only as fixed-length busy windows that end with an interrupt flag. A reset clears the result FIFO for a short fixed pulse. Standby gates the internal clock and holds reset for as long as it lasts. Leaving standby raises a completion flag after a settling delay.

Top module: `seq_ctrl_reg`

## Requirements
- R1: While `rst_n` is low and for the 2 cycles after it rises, read bit 1 (reset) is 1 and `fifo_clr_o` is 1. After that the whole read word is 0, the pointer is 0, the flags are clear and `clk_en_o` is 1.
- R2: Writing bit 0 = 1 while stopped and idle sets `run_o` and read bit 0 in the next cycle, and leaves the pointer unchanged.
- R3: Writing bit 0 = 0 while running keeps `run_o` high until `instr_done` is seen. `run_o` falls in the cycle after that report.
- R4: Each `instr_done` pulse seen while `run_o` is 1 increments `ip_o` by one, and the pointer wraps from 7 to 0. A pulse seen while stopped leaves it unchanged.
- R5: Writing bit 1 = 1 clears run, the pointer and every interrupt flag, and cancels any calibration. Read bit 1 and `fifo_clr_o` then stay high for exactly 2 cycles and return to 0 without further action.
- R6: Writing bit 2 = 1 while stopped raises `cal_busy_o` and read bit 2 at once for 76 cycles. Both then clear and `irq_short_o` sets.
- R7: Writing bit 3 = 1 while stopped raises `cal_busy_o` and read bit 3 for 4944 cycles. Both then clear and `irq_full_o` sets.
- R8: A calibration requested while running shows as pending in read bit 2 or 3 with `cal_busy_o` low, and starts on the next `instr_done`. During the calibration `run_o` is low. When it ends, `run_o` returns with the pointer where that report left it.
- R9: Writing bits 2 and 3 together runs only the full calibration; `irq_short_o` never sets for that request.
- R10: Writing bit 4 = 1 drops `clk_en_o` and `run_o` in the next cycle and clears the pointer and flags. Read bit 1 and `fifo_clr_o` are then held high for as long as standby lasts, and writes to bits 0, 2 and 3 are ignored.
- R11: Writing bit 4 = 0 in standby restores `clk_en_o` and gives the reset state, with the reset released 2 cycles later. `irq_stby_o` sets exactly 1024 cycles after the exit write.
- R12: Bits 5, 6 and 7 read back as written and drive `chan_mask_o`, `az_each_o` and `sync_oe_o` (1 = sync pin is an output).
- R13: With bit 7 = 0 and `run_o` high, a rising edge on `sync_i` gives a one-cycle `conv_trig_o` pulse in the next cycle. With bit 7 = 1, `sync_i` has no effect and `sync_o` follows `run_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data; bits 15:8 unused |
| rd_data | output | 16 | Live control and status word |
| instr_done | input | 1 | Sequencer reports the current instruction finished |
| ip_o | output | 3 | Instruction pointer |
| run_o | output | 1 | Sequencer may execute |
| fifo_clr_o | output | 1 | Result FIFO clear |
| clk_en_o | output | 1 | Internal clock enable, low in standby |
| cal_busy_o | output | 1 | A calibration window is active |
| az_each_o | output | 1 | Auto-zero before every conversion |
| chan_mask_o | output | 1 | Replace channel tag by sign in results |
| sync_oe_o | output | 1 | Sync pin drives out |
| sync_o | output | 1 | Sync pin output level |
| sync_i | input | 1 | Sync pin input level |
| conv_trig_o | output | 1 | Conversion start from a sync edge |
| irq_short_o | output | 1 | Short calibration complete flag |
| irq_full_o | output | 1 | Full calibration complete flag |
| irq_stby_o | output | 1 | Standby exit settled flag |

## Verification
Every output is a register or decodes registered state only. A write or an `instr_done` pulse therefore shows its effect in the first cycle after the capturing edge, and the bench checks that cycle as offset 0. The self-clearing results land at fixed offsets from that same point: the reset release at offset 2, the short calibration end at 76, the full calibration end at 4944 and the standby flag at 1024. A sync edge shows at offset 1 from the cycle the input changes. The bench books each expected value with its exact target cycle and compares it in that cycle, away from the clock edge. For the long windows it checks both the last busy cycle and the first idle cycle, so an off-by-one in either direction fails.

// File: rtl/seq_ctrl_reg.sv
module seq_ctrl_reg #(
  parameter int SHORT_CYC  = 76,
  parameter int FULL_CYC   = 4944,
  parameter int SETTLE_CYC = 1024,
  parameter int RST_HOLD   = 2,
  parameter int IPW        = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [15:0]    wr_data,
  output logic [15:0]    rd_data,
  input  logic           instr_done,
  output logic [IPW-1:0] ip_o,
  output logic           run_o,
  output logic           fifo_clr_o,
  output logic           clk_en_o,
  output logic           cal_busy_o,
  output logic           az_each_o,
  output logic           chan_mask_o,
  output logic           sync_oe_o,
  output logic           sync_o,
  input  logic           sync_i,
  output logic           conv_trig_o,
  output logic           irq_short_o,
  output logic           irq_full_o,
  output logic           irq_stby_o
);
  localparam int CW = $clog2(FULL_CYC + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int RW = $clog2(RST_HOLD + 1);

  typedef enum logic [1:0] {C_IDLE, C_PEND, C_SHORT, C_FULL} cal_e;

  cal_e           cal_st;
  logic           pend_full;
  logic [CW-1:0]  cal_cnt;
  logic           run_q, stop_pend, rst_q, stby_q;
  logic [RW-1:0]  rst_cnt;
  logic           settle_on;
  logic [SW-1:0]  settle_cnt;
  logic [IPW-1:0] ip_q;
  logic           mask_q, az_q, dir_q;
  logic           sync_q, trig_q;
  logic           irq_s, irq_f, irq_st;
  logic           busy, done_ok, bit2, bit3;
  logic           unused_hi;

  assign unused_hi = ^wr_data[15:8];

  assign busy    = (cal_st == C_SHORT) || (cal_st == C_FULL);
  assign run_o   = run_q && !rst_q && !stby_q && !busy;
  assign done_ok = instr_done && run_o;
  assign bit2    = (cal_st == C_SHORT) || (cal_st == C_PEND && !pend_full);
  assign bit3    = (cal_st == C_FULL)  || (cal_st == C_PEND &&  pend_full);

  assign rd_data     = {8'h00, dir_q, az_q, mask_q, stby_q, bit3, bit2, rst_q, run_q};
  assign ip_o        = ip_q;
  assign fifo_clr_o  = rst_q;
  assign clk_en_o    = !stby_q;
  assign cal_busy_o  = busy;
  assign az_each_o   = az_q;
  assign chan_mask_o = mask_q;
  assign sync_oe_o   = dir_q;
  assign sync_o      = dir_q && run_o;
  assign conv_trig_o = trig_q;
  assign irq_short_o = irq_s;
  assign irq_full_o  = irq_f;
  assign irq_stby_o  = irq_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_st     <= C_IDLE;
      pend_full  <= 1'b0;
      cal_cnt    <= '0;
      run_q      <= 1'b0;
      stop_pend  <= 1'b0;
      rst_q      <= 1'b1;
      rst_cnt    <= '0;
      stby_q     <= 1'b0;
      settle_on  <= 1'b0;
      settle_cnt <= '0;
      ip_q       <= '0;
      mask_q     <= 1'b0;
      az_q       <= 1'b0;
      dir_q      <= 1'b0;
      sync_q     <= 1'b0;
      trig_q     <= 1'b0;
      irq_s      <= 1'b0;
      irq_f      <= 1'b0;
      irq_st     <= 1'b0;
    end else begin
      sync_q <= sync_i;
      trig_q <= !dir_q && sync_i && !sync_q && run_o;

      if (done_ok) begin
        ip_q <= ip_q + 1'b1;
        if (stop_pend) begin
          run_q     <= 1'b0;
          stop_pend <= 1'b0;
        end
      end

      case (cal_st)
        C_PEND: if (done_ok) begin
          cal_st  <= pend_full ? C_FULL : C_SHORT;
          cal_cnt <= '0;
        end
        C_SHORT: if (cal_cnt == CW'(SHORT_CYC - 1)) begin
          cal_st <= C_IDLE;
          irq_s  <= 1'b1;
        end else cal_cnt <= cal_cnt + 1'b1;
        C_FULL: if (cal_cnt == CW'(FULL_CYC - 1)) begin
          cal_st <= C_IDLE;
          irq_f  <= 1'b1;
        end else cal_cnt <= cal_cnt + 1'b1;
        default: ;
      endcase

      if (rst_q && !stby_q) begin
        if (rst_cnt == RW'(RST_HOLD - 1)) rst_q <= 1'b0;
        else rst_cnt <= rst_cnt + 1'b1;
      end

      if (settle_on) begin
        if (settle_cnt == SW'(SETTLE_CYC - 1)) begin
          settle_on <= 1'b0;
          irq_st    <= 1'b1;
        end else settle_cnt <= settle_cnt + 1'b1;
      end

      if (wr_en) begin
        mask_q <= wr_data[5];
        az_q   <= wr_data[6];
        dir_q  <= wr_data[7];
        if (stby_q) begin
          if (!wr_data[4]) begin
            stby_q     <= 1'b0;
            rst_q      <= 1'b1;
            rst_cnt    <= '0;
            settle_on  <= 1'b1;
            settle_cnt <= '0;
          end
        end else if (wr_data[4] || wr_data[1]) begin
          stby_q    <= wr_data[4];
          rst_q     <= 1'b1;
          rst_cnt   <= '0;
          run_q     <= 1'b0;
          stop_pend <= 1'b0;
          ip_q      <= '0;
          irq_s     <= 1'b0;
          irq_f     <= 1'b0;
          irq_st    <= 1'b0;
          cal_st    <= C_IDLE;
          if (wr_data[4]) settle_on <= 1'b0;
        end else if (!rst_q) begin
          if (wr_data[0]) begin
            stop_pend <= 1'b0;
            if (!run_q && !busy) run_q <= 1'b1;
          end else if (run_q) begin
            stop_pend <= 1'b1;
          end
          if (cal_st == C_IDLE && (wr_data[2] || wr_data[3])) begin
            pend_full <= wr_data[3];
            cal_cnt   <= '0;
            if (run_o) cal_st <= C_PEND;
            else       cal_st <= wr_data[3] ? C_FULL : C_SHORT;
          end
        end
      end
    end
  end
endmodule

module seq_ctrl_reg_chk #(
  parameter int IPW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [15:0]    wr_data,
  input logic [15:0]    rd_data,
  input logic           instr_done,
  input logic [IPW-1:0] ip_o,
  input logic           run_o,
  input logic           fifo_clr_o,
  input logic           clk_en_o,
  input logic           cal_busy_o,
  input logic           conv_trig_o,
  input logic           irq_short_o,
  input logic           irq_full_o
);
  assert_stop_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !instr_done && !wr_en) |=> rd_data[0]);

  assert_ip_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && run_o && !wr_en) |=> (ip_o == $past(ip_o) + 1'b1));

  assert_reset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1] && clk_en_o) |=>
      (fifo_clr_o && !run_o && ip_o == '0 && !irq_short_o && !irq_full_o));

  assert_cal_end_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cal_busy_o) && !$past(wr_en)) |-> (irq_short_o || irq_full_o));

  assert_standby_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o |-> (fifo_clr_o && !run_o && rd_data[1]));

  assert_trig_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    conv_trig_o |=> !conv_trig_o);
endmodule

bind seq_ctrl_reg seq_ctrl_reg_chk #(.IPW(IPW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .instr_done(instr_done), .ip_o(ip_o), .run_o(run_o), .fifo_clr_o(fifo_clr_o),
  .clk_en_o(clk_en_o), .cal_busy_o(cal_busy_o), .conv_trig_o(conv_trig_o),
  .irq_short_o(irq_short_o), .irq_full_o(irq_full_o)
);

// File: tb/seq_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module seq_ctrl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        instr_done = 1'b0;
  logic        sync_i = 1'b0;
  logic [15:0] rd_data;
  logic [2:0]  ip_o;
  logic run_o, fifo_clr_o, clk_en_o, cal_busy_o, az_each_o, chan_mask_o;
  logic sync_oe_o, sync_o, conv_trig_o, irq_short_o, irq_full_o, irq_stby_o;

  always #2.5 clk = ~clk;

  seq_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .instr_done(instr_done), .ip_o(ip_o), .run_o(run_o), .fifo_clr_o(fifo_clr_o),
    .clk_en_o(clk_en_o), .cal_busy_o(cal_busy_o), .az_each_o(az_each_o),
    .chan_mask_o(chan_mask_o), .sync_oe_o(sync_oe_o), .sync_o(sync_o), .sync_i(sync_i),
    .conv_trig_o(conv_trig_o), .irq_short_o(irq_short_o), .irq_full_o(irq_full_o),
    .irq_stby_o(irq_stby_o)
  );

  logic [31:0] obs;
  assign obs = {1'b0, sync_oe_o, chan_mask_o, az_each_o, sync_o, conv_trig_o,
                irq_stby_o, irq_full_o, irq_short_o, cal_busy_o, clk_en_o,
                fifo_clr_o, run_o, ip_o, rd_data};

  localparam logic [31:0] M_ALL  = 32'h03FF_FFFF;
  localparam logic [31:0] M_IP   = 32'h0007_0000;
  localparam logic [31:0] M_TRIG = 32'h0400_0000;
  localparam logic [31:0] M_CFG  = 32'h7000_0000;

  typedef struct {
    int          cyc;
    logic [31:0] mask;
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] st(input logic [15:0] rd, input logic [2:0] ip,
      input logic run, input logic fc, input logic ce, input logic bz,
      input logic is_, input logic if_, input logic ist);
    return {6'b0, ist, if_, is_, bz, ce, fc, run, ip, rd};
  endfunction

  task automatic expect_at(input int d, input logic [31:0] m, input logic [31:0] v,
                           input string tag);
    item_t it;
    it.cyc = cyc + d; it.mask = m; it.val = v; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    #1;
    for (int k = q.size() - 1; k >= 0; k--) begin
      if (q[k].cyc <= cyc) begin
        n_run++;
        if (q[k].cyc < cyc || (obs & q[k].mask) !== q[k].val) begin
          n_fail++;
          $display("FAIL %s: cycle %0d actual %h expected %h (mask %h)",
                   q[k].tag, cyc, obs & q[k].mask, q[k].val, q[k].mask);
        end
        q.delete(k);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_done();
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_at(0, M_ALL, st(16'h0002, 0, 0, 1, 1, 0, 0, 0, 0), "R1 held");
    expect_at(1, M_ALL, st(16'h0002, 0, 0, 1, 1, 0, 0, 0, 0), "R1 held");
    expect_at(2, M_ALL, st(16'h0000, 0, 0, 0, 1, 0, 0, 0, 0), "R1 released");
    tick(4);

    wr(16'h00E0);
    expect_at(0, M_ALL | M_CFG, st(16'h00E0, 0, 0, 0, 1, 0, 0, 0, 0) | M_CFG, "R12 cfg");
    tick(1);
    wr(16'h0000);
    expect_at(0, M_CFG, 32'h0, "R12 cfg cleared");
    tick(1);

    wr(16'h0001);
    expect_at(0, M_ALL, st(16'h0001, 0, 1, 0, 1, 0, 0, 0, 0), "R2 start");
    for (int i = 1; i <= 8; i++) begin
      pulse_done();
      expect_at(0, M_IP, 32'(i % 8) << 16, "R4 advance");
    end

    sync_i = 1'b1;
    expect_at(1, M_TRIG, M_TRIG, "R13 edge trigger");
    expect_at(2, M_TRIG, 32'h0, "R13 one pulse");
    tick(3);
    sync_i = 1'b0;
    tick(2);
    wr(16'h0081);
    expect_at(0, 32'h4800_0000, 32'h4800_0000, "R13 sync out follows run");
    sync_i = 1'b1;
    expect_at(1, M_TRIG, 32'h0, "R13 output mode ignores input");
    expect_at(2, M_TRIG, 32'h0, "R13 output mode ignores input");
    tick(3);
    sync_i = 1'b0;
    wr(16'h0001);

    wr(16'h0000);
    expect_at(0, M_ALL, st(16'h0001, 0, 1, 0, 1, 0, 0, 0, 0), "R3 stop waits");
    tick(3);
    expect_at(0, M_ALL, st(16'h0001, 0, 1, 0, 1, 0, 0, 0, 0), "R3 still running");
    pulse_done();
    expect_at(0, M_ALL, st(16'h0000, 1, 0, 0, 1, 0, 0, 0, 0), "R3 stopped after done");
    pulse_done();
    expect_at(0, M_IP, 32'h0001_0000, "R4 no advance when stopped");

    wr(16'h0004);
    expect_at(0,  M_ALL, st(16'h0004, 1, 0, 0, 1, 1, 0, 0, 0), "R6 short busy");
    expect_at(75, M_ALL, st(16'h0004, 1, 0, 0, 1, 1, 0, 0, 0), "R6 short last busy");
    expect_at(76, M_ALL, st(16'h0000, 1, 0, 0, 1, 0, 1, 0, 0), "R6 short done");
    tick(80);

    wr(16'h0001);
    pulse_done();
    expect_at(0, M_ALL, st(16'h0001, 2, 1, 0, 1, 0, 1, 0, 0), "R5 pre state");
    wr(16'h0002);
    expect_at(0, M_ALL, st(16'h0002, 0, 0, 1, 1, 0, 0, 0, 0), "R5 reset");
    expect_at(1, M_ALL, st(16'h0002, 0, 0, 1, 1, 0, 0, 0, 0), "R5 reset hold");
    expect_at(2, M_ALL, st(16'h0000, 0, 0, 0, 1, 0, 0, 0, 0), "R5 self clear");
    tick(3);

    wr(16'h0001);
    wr(16'h0005);
    expect_at(0, M_ALL, st(16'h0005, 0, 1, 0, 1, 0, 0, 0, 0), "R8 pending");
    tick(4);
    expect_at(0, M_ALL, st(16'h0005, 0, 1, 0, 1, 0, 0, 0, 0), "R8 still pending");
    pulse_done();
    expect_at(0,  M_ALL, st(16'h0005, 1, 0, 0, 1, 1, 0, 0, 0), "R8 cal after done");
    expect_at(76, M_ALL, st(16'h0001, 1, 1, 0, 1, 0, 1, 0, 0), "R8 resume");
    tick(80);

    wr(16'h0000);
    pulse_done();
    wr(16'h0002);
    tick(3);
    wr(16'h000C);
    expect_at(0,    M_ALL, st(16'h0008, 0, 0, 0, 1, 1, 0, 0, 0), "R9 full chosen");
    expect_at(4943, M_ALL, st(16'h0008, 0, 0, 0, 1, 1, 0, 0, 0), "R7 full last busy");
    expect_at(4944, M_ALL, st(16'h0000, 0, 0, 0, 1, 0, 0, 1, 0), "R7 R9 full done");
    tick(4950);

    wr(16'h0001);
    pulse_done();
    pulse_done();
    wr(16'h0010);
    expect_at(0, M_ALL, st(16'h0012, 0, 0, 1, 0, 0, 0, 0, 0), "R10 standby");
    tick(5);
    expect_at(0, M_ALL, st(16'h0012, 0, 0, 1, 0, 0, 0, 0, 0), "R10 reset held");
    wr(16'h0015);
    expect_at(0, M_ALL, st(16'h0012, 0, 0, 1, 0, 0, 0, 0, 0), "R10 commands ignored");
    tick(3);

    wr(16'h0000);
    expect_at(0,    M_ALL, st(16'h0002, 0, 0, 1, 1, 0, 0, 0, 0), "R11 exit reset");
    expect_at(2,    M_ALL, st(16'h0000, 0, 0, 0, 1, 0, 0, 0, 0), "R11 released");
    expect_at(1023, M_ALL, st(16'h0000, 0, 0, 0, 1, 0, 0, 0, 0), "R11 settling");
    expect_at(1024, M_ALL, st(16'h0000, 0, 0, 0, 1, 0, 0, 0, 1), "R11 settled flag");
    tick(1030);

    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule